// File: doc/BRIEF.md
# Branch Direction and Target Predictor with Static Fallback

This block tells the fetch stage of a pipelined processor whether the branch at the current fetch address will be taken, and where it goes. It keeps a direct-mapped table of recently taken branches. The table is indexed by low bits of the fetch address, and each slot holds a tag, the last resolved destination and a 2-bit saturating direction counter. On a table hit, the prediction is the counter's upper bit, and the target comes from the slot. On a miss, a static rule applies: a branch whose decoded offset is negative (a backward jump, typical of loops) is predicted taken, and anything else is predicted not taken. The prediction and the next fetch address are combinational from the fetch inputs in the same cycle.

When a branch resolves in execute, the pipeline returns its address, its real outcome and target, and the prediction that was made for it. The block then trains the counter, refreshes the target, or claims a slot for a taken branch that missed. When the prediction was wrong, the block raises a one-cycle flush request one clock later, together with the address fetch must restart from. The flush request is driven by a two-state machine. State `RS_QUIET` means no flush is requested. State `RS_FLUSH` means a flush is requested. The transitions are:
- QUIET to FLUSH on a wrong resolve.
- FLUSH to FLUSH on a further wrong resolve.
- FLUSH to QUIET on any other cycle.
- QUIET to QUIET otherwise.

Top module: `bpred_top`

## Requirements
- R1: A synchronous reset clears every valid bit, so every lookup after reset is a miss and `fl_pulse` is 0.
- R2: On a miss (`pr_hit`=0), `pr_taken` equals bit 31 of `fe_offset` (negative offset means taken), `pr_target` is `fe_pc + fe_offset`, and `pr_next_pc` is `pr_target` when taken and `fe_pc + 4` otherwise.
- R3: On a hit, `pr_taken` is bit 1 of the slot's counter and `pr_target` is the stored destination. The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken.
- R4: A resolve that hits moves the counter one step toward its outcome (up on taken, down on not taken), saturating at 11 and at 00.
- R5: A resolve that misses allocates a slot only when the branch was taken. The slot gets valid=1, the tag, the resolved target and counter 10. A not-taken miss leaves the table unchanged.
- R6: A taken resolve that hits overwrites the stored destination with the resolved target.
- R7: The slot index is PC[IDX_W+1:2] and the tag is PC[PC_W-1:IDX_W+2]. A branch that shares an index but not a tag with a resident entry misses, and allocating it replaces that entry.
- R8: `fl_pulse` rises in the cycle after a resolve whose outcome differs from the predicted direction, or which was taken and predicted taken with a different target. `fl_pc` then shows the resolved target when taken and `rs_pc + 4` when not taken. A correct resolve produces no pulse. Two wrong resolves in consecutive cycles give two consecutive pulse cycles, each with its own address.
- R9: A backward loop branch re-run many times, with predictions fed back from the block, mispredicts only at the loop exit on every run, including the first.
- R10: A resolve changes the table at the clock edge on which it is presented. A lookup in that same cycle sees the old contents, and a lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fe_pc | input | PC_W | Fetch address being predicted |
| fe_offset | input | PC_W | Decoded signed branch offset of the fetched branch |
| pr_hit | output | 1 | Lookup found a matching valid slot |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | PC_W | Predicted destination |
| pr_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | PC_W | Actual destination |
| rs_pred_taken | input | 1 | Direction that was predicted for it |
| rs_pred_target | input | PC_W | Destination that was predicted for it |
| fl_pulse | output | 1 | One-cycle misprediction flush request |
| fl_pc | output | PC_W | Correct restart address while `fl_pulse` is high |

## Verification
The bench builds the block with PC_W=32 and IDX_W=4, a 16-slot table. This means branches 64 bytes apart collide. The random pool of ten branch addresses then forces frequent conflict misses, evictions and re-allocations alongside the directed counter walks through both saturation limits. With only 16 slots, the loop scenario and the aliasing pair can sit in known slots without filling the table.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef enum logic {
        RS_QUIET = 1'b0,
        RS_FLUSH = 1'b1
    } rs_state_e;

    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nx;
        nx = cur;
        unique case (cur)
            CTR_SNT: nx = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nx = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nx = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nx = taken ? CTR_ST  : CTR_WT;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/bpred_static.sv
module bpred_static #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] offset,
    output logic            st_taken,
    output logic [PC_W-1:0] st_target
);

    // Backward (negative) displacement: assume a loop and take it.
    always_comb begin
        st_taken  = offset[PC_W-1];
        st_target = pc + offset;
    end

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    // lookup port (fetch)
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output ctr_e            rd_ctr,
    output logic [PC_W-1:0] rd_tgt,
    // training port (resolve)
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_taken,
    input  logic [PC_W-1:0] wr_tgt
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam int IDX_L = 2;
    localparam int TAG_L = IDX_W + 2;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    ctr_e             ctr_q [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             wr_hit;
    ctr_e             wr_ctr;
    logic             unused_lo_bits;

    always_comb begin
        rd_idx = rd_pc[IDX_L +: IDX_W];
        rd_tag = rd_pc[TAG_L +: TAG_W];
        wr_idx = wr_pc[IDX_L +: IDX_W];
        wr_tag = wr_pc[TAG_L +: TAG_W];
        unused_lo_bits = ^{rd_pc[1:0], wr_pc[1:0]};
    end

    always_comb begin
        rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_ctr = ctr_q[rd_idx];
        rd_tgt = tgt_q[rd_idx];
        wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
        wr_ctr = ctr_q[wr_idx];
    end

    // One register slice per slot.
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[e] <= 1'b0;
            end else if (sel && wr_hit) begin
                ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
                if (wr_taken) begin
                    tgt_q[e] <= wr_tgt;
                end
            end else if (sel && wr_taken) begin
                vld_q[e] <= 1'b1;
                tag_q[e] <= wr_tag;
                tgt_q[e] <= wr_tgt;
                ctr_q[e] <= CTR_WT;
            end
        end
    end

    // R1: nothing is resident right after a reset cycle.
    assert_clear_on_reset_R1: assert property (@(posedge clk)
        rst |=> (!rd_hit && !wr_hit));

    // R5: a taken resolve leaves its branch resident.
    assert_taken_resident_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=> ((wr_pc != $past(wr_pc)) || wr_hit));

    // R5: a not-taken miss claims nothing.
    assert_no_alloc_untaken_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && !wr_hit) |=> ((wr_pc != $past(wr_pc)) || !wr_hit));

    // R4: saturation at the top.
    assert_sat_high_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit && wr_taken && wr_ctr == CTR_ST)
        |=> ((wr_pc != $past(wr_pc)) || wr_ctr == CTR_ST));

    // R4: saturation at the bottom.
    assert_sat_low_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hit && !wr_taken && wr_ctr == CTR_SNT)
        |=> ((wr_pc != $past(wr_pc)) || wr_ctr == CTR_SNT));

endmodule

// File: rtl/bpred_resolve.sv
module bpred_resolve
    import bpred_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_pred_taken,
    input  logic [PC_W-1:0] rs_pred_target,
    output logic            fl_pulse,
    output logic [PC_W-1:0] fl_pc
);

    rs_state_e       state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic            wrong;
    logic [PC_W-1:0] fix_pc;

    always_comb begin
        wrong  = rs_valid &&
                 ((rs_taken != rs_pred_taken) ||
                  (rs_taken && (rs_target != rs_pred_target)));
        fix_pc = rs_taken ? rs_target : (rs_pc + PC_W'(4));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_QUIET: state_d = wrong ? RS_FLUSH : RS_QUIET;
            RS_FLUSH: state_d = wrong ? RS_FLUSH : RS_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_QUIET;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (wrong) begin
                pc_q <= fix_pc;
            end
        end
    end

    always_comb begin
        fl_pulse = 1'b0;
        fl_pc    = '0;
        unique case (state_q)
            RS_QUIET: ;
            RS_FLUSH: begin
                fl_pulse = 1'b1;
                fl_pc    = pc_q;
            end
        endcase
    end

    // R8: a flush request always follows a resolve.
    assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        fl_pulse |-> $past(rs_valid));

    // R8: a correct prediction never flushes.
    assert_right_no_flush_R8: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && (rs_taken == rs_pred_taken) &&
         (!rs_taken || (rs_target == rs_pred_target))) |=> !fl_pulse);

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fe_pc,
    input  logic [PC_W-1:0] fe_offset,
    output logic            pr_hit,
    output logic            pr_taken,
    output logic [PC_W-1:0] pr_target,
    output logic [PC_W-1:0] pr_next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_pred_taken,
    input  logic [PC_W-1:0] rs_pred_target,
    output logic            fl_pulse,
    output logic [PC_W-1:0] fl_pc
);

    logic            hit;
    ctr_e            hit_ctr;
    logic [PC_W-1:0] hit_tgt;
    logic            st_taken;
    logic [PC_W-1:0] st_target;

    bpred_btb #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb (
        .clk      (clk),
        .rst      (rst),
        .rd_pc    (fe_pc),
        .rd_hit   (hit),
        .rd_ctr   (hit_ctr),
        .rd_tgt   (hit_tgt),
        .wr_en    (rs_valid),
        .wr_pc    (rs_pc),
        .wr_taken (rs_taken),
        .wr_tgt   (rs_target)
    );

    bpred_static #(.PC_W(PC_W)) u_static (
        .pc        (fe_pc),
        .offset    (fe_offset),
        .st_taken  (st_taken),
        .st_target (st_target)
    );

    bpred_resolve #(.PC_W(PC_W)) u_resolve (
        .clk            (clk),
        .rst            (rst),
        .rs_valid       (rs_valid),
        .rs_pc          (rs_pc),
        .rs_taken       (rs_taken),
        .rs_target      (rs_target),
        .rs_pred_taken  (rs_pred_taken),
        .rs_pred_target (rs_pred_target),
        .fl_pulse       (fl_pulse),
        .fl_pc          (fl_pc)
    );

    always_comb begin
        pr_hit     = hit;
        pr_taken   = hit ? hit_ctr[1] : st_taken;
        pr_target  = hit ? hit_tgt : st_target;
        pr_next_pc = pr_taken ? pr_target : (fe_pc + PC_W'(4));
    end

    // R2: a miss follows the sign of the offset.
    assert_static_fallback_R2: assert property (@(posedge clk) disable iff (rst)
        !pr_hit |-> (pr_taken == fe_offset[PC_W-1]));

    // R3: a taken-leaning counter predicts taken on a hit.
    assert_hit_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (pr_hit && (hit_ctr == CTR_WT || hit_ctr == CTR_ST)) |-> pr_taken);

endmodule

// File: tb/bpred_top_tb.sv
`timescale 1ns/1ps
module bpred_top_tb;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst;
    logic [PC_W-1:0] fe_pc, fe_offset;
    logic            pr_hit, pr_taken;
    logic [PC_W-1:0] pr_target, pr_next_pc;
    logic            rs_valid, rs_taken, rs_pred_taken;
    logic [PC_W-1:0] rs_pc, rs_target, rs_pred_target;
    logic            fl_pulse;
    logic [PC_W-1:0] fl_pc;

    bpred_top #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .fe_pc(fe_pc), .fe_offset(fe_offset),
        .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target),
        .pr_next_pc(pr_next_pc), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_taken(rs_taken), .rs_target(rs_target),
        .rs_pred_taken(rs_pred_taken), .rs_pred_target(rs_pred_target),
        .fl_pulse(fl_pulse), .fl_pc(fl_pc)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference table, built from the requirements.
    bit               m_vld [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];
    logic [1:0]       m_ctr [DEPTH];

    function automatic int f_idx(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic [TAG_W-1:0] f_tag(input logic [PC_W-1:0] pc);
        return pc[PC_W-1:IDX_W+2];
    endfunction

    function automatic bit m_hit(input logic [PC_W-1:0] pc);
        return m_vld[f_idx(pc)] && (m_tag[f_idx(pc)] == f_tag(pc));
    endfunction

    task automatic m_clear();
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    endtask

    task automatic m_update(input logic [PC_W-1:0] pc, input bit tk,
                            input logic [PC_W-1:0] tg);
        int i;
        i = f_idx(pc);
        if (m_hit(pc)) begin
            if (tk && m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
            if (!tk && m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'd1;
            if (tk) m_tgt[i] = tg;
        end else if (tk) begin
            m_vld[i] = 1'b1;
            m_tag[i] = f_tag(pc);
            m_tgt[i] = tg;
            m_ctr[i] = 2'b10;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge: drive fetch and compare.
    task automatic predict(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] off,
                           input string req);
        bit h, tk;
        logic [PC_W-1:0] tg;
        fe_pc = pc;
        fe_offset = off;
        #1;
        h  = m_hit(pc);
        tk = h ? m_ctr[f_idx(pc)][1] : off[PC_W-1];
        tg = h ? m_tgt[f_idx(pc)] : pc + off;
        chk(req, "hit",    {31'd0, pr_hit},   {31'd0, h});
        chk(req, "taken",  {31'd0, pr_taken}, {31'd0, tk});
        chk(req, "target", pr_target, tg);
        chk(req, "next",   pr_next_pc, tk ? tg : pc + 32'd4);
    endtask

    // Drive one resolve, cross a rising edge, check the flush at the next fall.
    task automatic resolve(input logic [PC_W-1:0] pc, input bit tk,
                           input logic [PC_W-1:0] tg, input bit ptk,
                           input logic [PC_W-1:0] ptg, input string req,
                           output bit pulsed);
        bit wrong;
        logic [PC_W-1:0] fix;
        rs_valid = 1'b1;
        rs_pc = pc; rs_taken = tk; rs_target = tg;
        rs_pred_taken = ptk; rs_pred_target = ptg;
        wrong = (tk != ptk) || (tk && (tg != ptg));
        fix = tk ? tg : pc + 32'd4;
        @(posedge clk);
        m_update(pc, tk, tg);
        @(negedge clk);
        pulsed = fl_pulse;
        chk(req, "fl_pulse", {31'd0, fl_pulse}, {31'd0, wrong});
        if (wrong) chk(req, "fl_pc", fl_pc, fix);
        rs_valid = 1'b0;
    endtask

    task automatic step(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] off,
                        input bit tk, input logic [PC_W-1:0] tg, input string req,
                        output bit pulsed);
        predict(pc, off, req);
        resolve(pc, tk, tg, pr_taken, pr_target, req, pulsed);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        m_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    localparam logic [PC_W-1:0] PA = 32'h0000_0208;
    localparam logic [PC_W-1:0] PB = 32'h0000_0310;
    localparam logic [PC_W-1:0] PC2 = PB + 32'(DEPTH * 4);
    localparam logic [PC_W-1:0] PL = 32'h0000_0430;

    initial begin
        bit p;
        int cnt;
        logic [PC_W-1:0] pool [10];
        void'($urandom(32'd2024));
        rs_valid = 0; rs_pc = 0; rs_taken = 0; rs_target = 0;
        rs_pred_taken = 0; rs_pred_target = 0; fe_pc = 0; fe_offset = 0;
        m_clear();
        @(negedge clk);
        do_reset();

        // R1: after reset, nothing hits and no flush.
        chk("R1", "fl_pulse after reset", {31'd0, fl_pulse}, 32'd0);
        predict(PB, 32'h40, "R1");

        // R2: static rule on misses, both signs.
        predict(32'h0000_0100, 32'h0000_0040, "R2");
        predict(32'h0000_0100, 32'hFFFF_FFE0, "R2");
        predict(32'h0000_0104, 32'h0000_0000, "R2");

        // R5: not-taken miss does not allocate.
        step(PA, 32'h20, 1'b0, PA + 32'h20, "R5", p);
        predict(PA, 32'hFFFF_FFF0, "R5");
        chk("R5", "no alloc on not-taken", {31'd0, pr_hit}, 32'd0);

        // R10: same-cycle lookup sees old contents; next cycle sees new.
        predict(PB, 32'h80, "R10");
        rs_valid = 1'b1; rs_pc = PB; rs_taken = 1'b1; rs_target = 32'h0000_0900;
        rs_pred_taken = pr_taken; rs_pred_target = pr_target;
        #1;
        chk("R10", "same-cycle hit", {31'd0, pr_hit}, 32'd0);
        @(posedge clk);
        m_update(PB, 1'b1, 32'h0000_0900);
        @(negedge clk);
        rs_valid = 1'b0;
        chk("R8", "fl_pulse on wrong direction", {31'd0, fl_pulse}, 32'd1);
        chk("R8", "fl_pc taken", fl_pc, 32'h0000_0900);
        #1;
        chk("R10", "next-cycle hit", {31'd0, pr_hit}, 32'd1);
        // R3/R5: weakly taken after allocation, stored target.
        predict(PB, 32'h80, "R3");
        chk("R5", "alloc target", pr_target, 32'h0000_0900);

        // R4: walk up to saturation and back down through the floor.
        for (int k = 0; k < 3; k++) step(PB, 32'h80, 1'b1, 32'h0000_0900, "R4", p);
        for (int k = 0; k < 5; k++) step(PB, 32'h80, 1'b0, 32'h0000_0900, "R4", p);
        predict(PB, 32'hFFFF_FF00, "R4");
        chk("R4", "floor predicts not taken", {31'd0, pr_taken}, 32'd0);
        step(PB, 32'h80, 1'b1, 32'h0000_0900, "R4", p);
        predict(PB, 32'h80, "R4");
        chk("R4", "one up from floor still not taken", {31'd0, pr_taken}, 32'd0);
        step(PB, 32'h80, 1'b1, 32'h0000_0900, "R4", p);

        // R6 and R8: taken, predicted taken, wrong target.
        step(PB, 32'h80, 1'b1, 32'h0000_0A00, "R6", p);
        predict(PB, 32'h80, "R6");
        chk("R6", "target refreshed", pr_target, 32'h0000_0A00);

        // R8: correct prediction, no pulse; then two wrong in a row.
        step(PB, 32'h80, 1'b1, 32'h0000_0A00, "R8", p);
        resolve(PA, 1'b1, 32'h0000_0C00, 1'b0, 32'h0, "R8", p);
        resolve(PA, 1'b0, 32'h0000_0C00, 1'b1, 32'h0000_0C00, "R8", p);
        chk("R8", "back-to-back pc", fl_pc, PA + 32'd4);

        // R7: alias at the same index with another tag.
        predict(PC2, 32'h10, "R7");
        chk("R7", "alias misses", {31'd0, pr_hit}, 32'd0);
        step(PC2, 32'h10, 1'b1, 32'h0000_0B00, "R7", p);
        predict(PB, 32'h80, "R7");
        chk("R7", "evicted misses", {31'd0, pr_hit}, 32'd0);

        // R9: loop branch, three runs of nine taken then exit.
        for (int run = 0; run < 3; run++) begin
            cnt = 0;
            for (int it = 0; it < 10; it++) begin
                step(PL, 32'hFFFF_FFF0, (it < 9), PL - 32'h10, "R9", p);
                if (p) cnt++;
            end
            chk("R9", "mispredicts per loop run", 32'(cnt), 32'd1);
        end

        // Random traffic over a pool with aliasing.
        for (int k = 0; k < 6; k++) pool[k] = 32'h0000_1000 + 32'(k * 4);
        for (int k = 0; k < 4; k++) pool[6 + k] = 32'h0000_1000 + 32'(DEPTH * 4) + 32'(k * 4);
        for (int n = 0; n < 1500; n++) begin
            logic [PC_W-1:0] pc, off, tg;
            bit tk;
            pc  = pool[$urandom % 10];
            off = 32'((int'($urandom % 128) - 64) * 4);
            tk  = ($urandom % 10) < 7;
            tg  = (($urandom % 8) == 0) ? pc + 32'(($urandom % 256) * 4) : pc + off;
            step(pc, off, tk, tg, "R3", p);
        end

        // R1: reset mid-run empties the table.
        do_reset();
        for (int k = 0; k < 10; k++) begin
            predict(pool[k], 32'hFFFF_FFF0, "R1");
            chk("R1", "miss after reset", {31'd0, pr_hit}, 32'd0);
        end
        chk("R1", "fl_pulse after reset", {31'd0, fl_pulse}, 32'd0);

        summary();
    end

endmodule